// File: doc/BRIEF.md
# Configurable 16-bit Base Timer

This block is the shared time base of an input-capture/output-compare unit. It holds a free-running 16-bit counter that software starts and stops through a run bit, presets through a write port and observes through a read port. The read port returns the count plus one. The counter can advance in three ways. It can be stopped. It can step on an internal clock enable at full or half rate. It can also follow a pair of two-phase (quadrature) inputs, counting up or down.

On every up-count that carries out of a chosen bit (bit 15 or bit 14), the timer raises a one-cycle interrupt pulse. When a compare register matches, the counter can clear itself. It can also be cleared from an external reset input, gated by its own enable. A timer that is not running is held at zero, and writes to it are dropped.

Top module: `base_timer16`

## Requirements
- R1: While `run` is 0 the counter is forced to zero on every clock edge and a write through `wr_en` has no effect; after `run` returns to 1 the count starts from zero.
- R2: `rd_value` equals the current count plus one, modulo 2^16, so a count of 0xFFFF reads as 0x0000.
- R3: While running, a write loads `wr_value` into the counter at the next edge, overriding any clear or count step in that cycle.
- R4: With `src_sel` = 00 (stopped) or 01 (reserved), the counter does not step, whatever the internal rate or the two-phase inputs do.
- R5: With `src_sel` = 11, the counter steps up once per clock when `fast_sel` is 1, and once every second clock when `fast_sel` is 0. The first half-rate step lands on the second edge after the source is selected.
- R6: With `src_sel` = 10, each edge on `phase_a` or `phase_b` moves the count by one after two synchronizer stages. The visible count changes on the third clock edge after the pin change. The count goes up when A leads B, i.e. the {a,b} sequence 00,10,11,01. It goes down when B leads A, i.e. the sequence 00,01,11,10.
- R7: `irq_pulse` is high for exactly one cycle, in the cycle after an up-step that carries out of bit 15 (`tap_sel` = 0, count 0xFFFF to 0x0000) or out of bit 14 (`tap_sel` = 1, low 15 bits all ones). No other step raises it.
- R8: With `match_clr_en` = 1, a count equal to `cmp_value` is replaced by zero at the next edge instead of stepping.
- R9: With `ext_clr_en` = 1, a high `ext_clr_in` clears the count at the next edge. With `ext_clr_en` = 0 the input is ignored. The two clear enables are never set together.
- R10: After reset, `irq_pulse` is 0, the counter is zero and the rate divider and synchronizers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 lets the counter run, 0 holds it at zero |
| src_sel | input | 2 | Count source: 00 off, 01 reserved, 10 two-phase, 11 internal |
| fast_sel | input | 1 | Internal rate: 1 every clock, 0 every second clock |
| tap_sel | input | 1 | Overflow tap: 0 bit 15, 1 bit 14 |
| match_clr_en | input | 1 | Enables clearing on compare match |
| cmp_value | input | 16 | Reset-compare value |
| ext_clr_en | input | 1 | Enables the external clear input |
| ext_clr_in | input | 1 | External clear request |
| phase_a | input | 1 | Two-phase input A (asynchronous) |
| phase_b | input | 1 | Two-phase input B (asynchronous) |
| wr_en | input | 1 | Counter preload strobe |
| wr_value | input | 16 | Preload value |
| rd_value | output | 16 | Count plus one |
| irq_pulse | output | 1 | One-cycle overflow interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, taps at bits 15 and 14, and two synchronizer stages. At that width, both overflow taps and the wrap of the read offset are reached by preloading values next to 0x7FFF and 0xFFFF, so a few clocks suffice. The two-stage synchronizer puts every two-phase step at a fixed three-edge latency, so each quadrature edge can be checked exactly.

// File: rtl/base_timer_pkg.sv
package base_timer_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_RSVD = 2'b01,
    SRC_QUAD = 2'b10,
    SRC_INT  = 2'b11
  } src_e;

  // True when an up-step from cnt carries out of bit `tap`.
  function automatic logic carries_out(input logic [31:0] cnt, input int tap);
    logic all_ones;
    all_ones = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i <= tap && !cnt[i]) all_ones = 1'b0;
    end
    return all_ones;
  endfunction

  // Direction of a single-bit two-phase transition: 1 means up.
  function automatic logic quad_is_up(input logic prev_b, input logic cur_a);
    return cur_a ^ prev_b;
  endfunction

endpackage

// File: rtl/bt_rate_gen.sv
module bt_rate_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fast,
  output logic tick
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (!enable) half_q <= 1'b0;
    else              half_q <= ~half_q;
  end

  assign tick = enable & (fast | half_q);

  // R5: at half rate no two ticks follow each other
  p_half_rate_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fast && tick) |=> !tick);
endmodule

// File: rtl/bt_quad_decode.sv
module bt_quad_decode #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pin_a,
  input  logic pin_b,
  output logic step_up,
  output logic step_dn
);
  import base_timer_pkg::*;

  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic prev_a, prev_b;
  logic cur_a, cur_b;
  logic single_change;

  assign cur_a = sync_a[SYNC_STAGES-1];
  assign cur_b = sync_b[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], pin_a};
      sync_b <= {sync_b[SYNC_STAGES-2:0], pin_b};
      prev_a <= cur_a;
      prev_b <= cur_b;
    end
  end

  assign single_change = (cur_a ^ prev_a) ^ (cur_b ^ prev_b);
  assign step_up = enable & single_change &  quad_is_up(prev_b, cur_a);
  assign step_dn = enable & single_change & ~quad_is_up(prev_b, cur_a);

  // R6: a step is only reported when a synchronized input moved
  p_step_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> (cur_a != prev_a || cur_b != prev_b));
endmodule

// File: rtl/bt_count_core.sv
module bt_count_core #(
  parameter int WIDTH  = 16,
  parameter int TAP_HI = WIDTH - 1,
  parameter int TAP_LO = WIDTH - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_value,
  input  logic             clr_req,
  input  logic             up,
  input  logic             dn,
  input  logic             tap_sel,
  output logic [WIDTH-1:0] count,
  output logic             irq
);
  import base_timer_pkg::*;

  logic carry_evt;
  assign carry_evt = up & carries_out(32'(count), tap_sel ? TAP_LO : TAP_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!run)         count <= '0;
      else if (wr_en)   count <= wr_value;
      else if (clr_req) count <= '0;
      else if (up) begin
        count <= count + 1'b1;
        irq   <= carry_evt;
      end else if (dn)  count <= count - 1'b1;
    end
  end

  // R1: an idle timer sits at zero
  p_hold_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);
  // R3: a write while running lands exactly
  p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en) |=> count == $past(wr_value));
  // R4: no step request and no clear leaves the count alone
  p_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_en && !clr_req && !up && !dn) |=> $stable(count));
  // R7: the interrupt never lasts two cycles
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7: the interrupt follows a wrap of the selected tap
  p_irq_after_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(up && run && !wr_en && !clr_req));
endmodule

// File: rtl/base_timer16.sv
module base_timer16 #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       src_sel,
  input  logic             fast_sel,
  input  logic             tap_sel,
  input  logic             match_clr_en,
  input  logic [WIDTH-1:0] cmp_value,
  input  logic             ext_clr_en,
  input  logic             ext_clr_in,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_value,
  output logic [WIDTH-1:0] rd_value,
  output logic             irq_pulse
);
  import base_timer_pkg::*;

  localparam int TAP_HI = WIDTH - 1;
  localparam int TAP_LO = WIDTH - 2;

  src_e             src;
  logic             int_tick, quad_up, quad_dn;
  logic             step_up, step_dn;
  logic             match_hit, clr_req;
  logic [WIDTH-1:0] count;

  assign src = src_e'(src_sel);

  bt_rate_gen u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (run && src == SRC_INT),
    .fast   (fast_sel),
    .tick   (int_tick)
  );

  bt_quad_decode #(.SYNC_STAGES(SYNC_STAGES)) u_quad (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (src == SRC_QUAD),
    .pin_a   (phase_a),
    .pin_b   (phase_b),
    .step_up (quad_up),
    .step_dn (quad_dn)
  );

  assign step_up   = int_tick | quad_up;
  assign step_dn   = quad_dn;
  assign match_hit = match_clr_en && (count == cmp_value);
  assign clr_req   = match_hit | (ext_clr_en & ext_clr_in);

  bt_count_core #(.WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .wr_en    (wr_en),
    .wr_value (wr_value),
    .clr_req  (clr_req),
    .up       (step_up),
    .dn       (step_dn),
    .tap_sel  (tap_sel),
    .count    (count),
    .irq      (irq_pulse)
  );

  assign rd_value = count + 1'b1;

  // R8: a match with clearing enabled yields zero next
  p_match_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_en && match_hit) |=> count == '0);
  // R9: the two clear enables are exclusive
  p_clr_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_clr_en && ext_clr_en));
  // R4: stopped and reserved sources never request a step
  p_quiet_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel[1] == 1'b0) |-> !(step_up || step_dn));
endmodule

// File: tb/base_timer16_test.sv
module base_timer16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic        fast_sel = 1'b1;
  logic        tap_sel = 1'b0;
  logic        match_clr_en = 1'b0;
  logic [15:0] cmp_value = '0;
  logic        ext_clr_en = 1'b0;
  logic        ext_clr_in = 1'b0;
  logic        phase_a = 1'b0;
  logic        phase_b = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_value = '0;
  logic [15:0] rd_value;
  logic        irq_pulse;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  always #2 clk = ~clk;

  base_timer16 uut (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel), .fast_sel(fast_sel),
    .tap_sel(tap_sel), .match_clr_en(match_clr_en), .cmp_value(cmp_value),
    .ext_clr_en(ext_clr_en), .ext_clr_in(ext_clr_in), .phase_a(phase_a),
    .phase_b(phase_b), .wr_en(wr_en), .wr_value(wr_value), .rd_value(rd_value),
    .irq_pulse(irq_pulse)
  );

  always @(negedge clk) if (irq_pulse) irq_seen++;

  // preload, tap, fast, edges with internal source, expected read, expected irqs
  localparam logic [45:0] TBL [0:6] = '{
    {16'h0000, 1'b0, 1'b1, 8'd10, 16'h000B, 4'd0},
    {16'hFFFE, 1'b0, 1'b1, 8'd4,  16'h0003, 4'd1},
    {16'h7FFE, 1'b1, 1'b1, 8'd3,  16'h8002, 4'd1},
    {16'h7FFE, 1'b0, 1'b1, 8'd3,  16'h8002, 4'd0},
    {16'h0100, 1'b0, 1'b0, 8'd8,  16'h0105, 4'd0},
    {16'hFFFF, 1'b1, 1'b1, 8'd1,  16'h0001, 4'd1},
    {16'h3FFF, 1'b1, 1'b1, 8'd2,  16'h4002, 4'd0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic preload(input logic [15:0] v);
    @(negedge clk); src_sel = 2'b00; wr_en = 1'b1; wr_value = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    wait_neg(3);
    chk("R10 irq after reset", {15'd0, irq_pulse}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    chk("R10 zero count reads one (R2)", rd_value, 16'h0001);

    // R1: writes dropped while idle, and idle forces zero
    @(negedge clk); run = 1'b0; wr_en = 1'b1; wr_value = 16'h1234;
    @(negedge clk); wr_en = 1'b0; run = 1'b1;
    @(negedge clk);
    chk("R1 write ignored while idle", rd_value, 16'h0001);
    preload(16'h0055);
    chk("R3 preload while running", rd_value, 16'h0056);
    @(negedge clk); run = 1'b0;
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    chk("R1 idle clears count", rd_value, 16'h0001);

    // table: R5 rates, R7 taps, R2 wrap
    for (int k = 0; k < 7; k++) begin
      logic [45:0] v;
      v = TBL[k];
      preload(v[45:30]);
      tap_sel = v[29]; fast_sel = v[28];
      irq_seen = 0;
      src_sel = 2'b11;
      repeat (v[27:20]) @(posedge clk);
      @(negedge clk); src_sel = 2'b00;
      @(negedge clk);
      chk($sformatf("R5 table entry %0d read", k), rd_value, v[19:4]);
      chk($sformatf("R7 table entry %0d irq count", k), 16'(irq_seen), {12'd0, v[3:0]});
    end
    tap_sel = 1'b0; fast_sel = 1'b1;

    // R2: count 0xFFFF reads as 0x0000
    preload(16'hFFFF);
    chk("R2 read wraps", rd_value, 16'h0000);

    // R4: reserved source does nothing
    preload(16'h0020);
    src_sel = 2'b01;
    wait_neg(5);
    chk("R4 reserved source stays", rd_value, 16'h0021);
    src_sel = 2'b00;

    // R8: match clear at 5
    preload(16'h0000);
    cmp_value = 16'h0005; match_clr_en = 1'b1;
    src_sel = 2'b11;
    wait_neg(5);
    chk("R8 reaches compare value", rd_value, 16'h0006);
    wait_neg(1);
    chk("R8 cleared after match", rd_value, 16'h0001);
    wait_neg(1);
    chk("R8 counting resumes", rd_value, 16'h0002);
    src_sel = 2'b00; match_clr_en = 1'b0;

    // R9: external clear gating
    preload(16'h00AA);
    ext_clr_in = 1'b1;
    wait_neg(2);
    chk("R9 disabled external clear ignored", rd_value, 16'h00AB);
    ext_clr_en = 1'b1;
    wait_neg(1);
    chk("R9 external clear", rd_value, 16'h0001);
    ext_clr_en = 1'b0; ext_clr_in = 1'b0;

    // R6: two-phase counting
    preload(16'h0010);
    src_sel = 2'b10;
    wait_neg(4);
    phase_a = 1'b1;
    wait_neg(2);
    chk("R6 no step before third edge", rd_value, 16'h0011);
    wait_neg(1);
    chk("R6 step on third edge", rd_value, 16'h0012);
    phase_b = 1'b1; wait_neg(4);
    phase_a = 1'b0; wait_neg(4);
    phase_b = 1'b0; wait_neg(4);
    chk("R6 A leads B counts up", rd_value, 16'h0015);
    phase_b = 1'b1; wait_neg(4);
    phase_a = 1'b1; wait_neg(4);
    phase_b = 1'b0; wait_neg(4);
    chk("R6 B leads A counts down", rd_value, 16'h0012);
    src_sel = 2'b00;
    phase_a = 1'b0; wait_neg(4);
    chk("R4 two-phase edges ignored when stopped", rd_value, 16'h0012);

    finish_run();
  end
endmodule